// File: doc/BRIEF.md
# Vector Integer Reduction Unit

This block folds the elements of one source vector register into a single scalar and delivers a destination register image. Element 0 holds the result and every other bit is zero. The scalar seed comes from a separate operand. The block also takes the source vector, the per-element mask register, the active vector length and the selected element width. The decoded instruction word selects one of eight operations: wrapping sum, bitwise AND, OR and XOR, and signed or unsigned minimum and maximum.

A start strobe latches all operands. The block then visits one element per clock, in ascending index order. Elements that the mask switches off are passed over. When the last element has been handled, the block presents the finished image together with a one-cycle done pulse. If the instruction word is not a legal reduction, the block raises a one-cycle illegal flag instead and leaves the destination image untouched. Register-file storage lies outside the block.

Top module: `vred_unit`

## Requirements
- R1: An instruction is legal only when bits [6:0] equal 1010111, bits [14:12] equal 010 and bits [31:29] equal 000. Bits [28:26] then select the operation: 0 sum, 1 AND, 2 OR, 3 XOR, 4 unsigned min, 5 signed min, 6 unsigned max, 7 signed max.
- R2: The accumulator starts from the low SEW bits of `seed_i`, not from an identity value.
- R3: Source elements 0 to vl-1 are combined in ascending order, and the sum wraps modulo 2^SEW.
- R4: Minimum and maximum compare as two's-complement signed values for codes 5 and 7, and as unsigned values for codes 4 and 6.
- R5: With instruction bit 25 (vm) at 0, element i is skipped when `mask_i[i]` is 0. With vm at 1, every element below vl is used.
- R6: `ew_i` selects SEW: 00 gives 8, 01 gives 16, 10 gives 32, 11 gives 64. Element i occupies `src_i[i*SEW +: SEW]`.
- R7: The result is placed in `dest_o[SEW-1:0]`, and every higher bit of `dest_o` is zero.
- R8: When vl is 0, the result equals the seed masked to SEW, and the upper bits are still zero.
- R9: After an accepted start edge, `busy_o` is high, and `done_o` pulses for exactly one cycle vl+1 clock edges later, at the moment `dest_o` is updated.
- R10: A start while busy is ignored. It changes neither the running result nor the timing, and it causes no extra done or illegal pulse.
- R11: A start with an illegal instruction pulses `illegal_o` on the next cycle, does not set busy, gives no done pulse and leaves `dest_o` unchanged.
- R12: During reset, `dest_o` is zero and `busy_o`, `done_o` and `illegal_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled when idle |
| instr_i | input | 32 | Instruction word |
| ew_i | input | 2 | Element width select |
| vl_i | input | VLW | Active vector length, at most VLEN/SEW |
| seed_i | input | 64 | Scalar seed element |
| src_i | input | VLEN | Source vector register |
| mask_i | input | VLEN/8 | Mask register, one bit per element index |
| busy_o | output | 1 | Reduction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle illegal-instruction pulse |
| dest_o | output | VLEN | Destination register image |

## Verification
Two events can fall on the same clock edge. One is the edge that completes a reduction and writes the result. The other is a new start request, which arrives while the block still reports busy. The bench holds start high from the middle of a reduction through its final edge, with both a legal word and an illegal word. It then checks three things: the finished value matches the first operation's reference, done appears exactly once at the expected latency, and no illegal pulse or second reduction follows. Random operations, widths, masks and lengths fill in the rest, and each is compared against a reference model written in the bench.

// File: rtl/vred_pkg.sv
// Package: shared types and helpers for the reduction unit.
// Assumes a 64-bit widest element; every element width divides VLEN.
package vred_pkg;
    localparam int DW = 64;
    localparam logic [6:0] VEC_MAJOR = 7'b1010111;
    localparam logic [2:0] RED_F3    = 3'b010;

    typedef enum logic [2:0] {
        OP_SUM  = 3'd0, OP_AND  = 3'd1, OP_OR   = 3'd2, OP_XOR = 3'd3,
        OP_MINU = 3'd4, OP_MIN  = 3'd5, OP_MAXU = 3'd6, OP_MAX = 3'd7
    } red_op_e;

    typedef enum logic [1:0] { EW8 = 2'd0, EW16 = 2'd1, EW32 = 2'd2, EW64 = 2'd3 } ew_e;

    // Keep-mask for the low SEW bits.
    function automatic logic [DW-1:0] ew_keep(ew_e w);
        case (w)
            EW8:     return 64'h0000_0000_0000_00FF;
            EW16:    return 64'h0000_0000_0000_FFFF;
            EW32:    return 64'h0000_0000_FFFF_FFFF;
            default: return {DW{1'b1}};
        endcase
    endfunction

    // Element width in bits.
    function automatic int unsigned ew_bits(ew_e w);
        return 32'd8 << w;
    endfunction

    // Sign-extend the low SEW bits to 65 bits for signed compares.
    function automatic logic signed [DW:0] ew_sext(logic [DW-1:0] x, ew_e w);
        case (w)
            EW8:     return {{57{x[7]}}, x[7:0]};
            EW16:    return {{49{x[15]}}, x[15:0]};
            EW32:    return {{33{x[31]}}, x[31:0]};
            default: return {x[63], x};
        endcase
    endfunction
endpackage

// File: rtl/vred_decode.sv
// Module: instruction decoder for the reduction unit.
// Checks the major opcode, funct3 and funct6 high bits, then yields
// the operation code and the vm bit. Purely combinational.
module vred_decode
    import vred_pkg::*;
(
    input  logic [31:0] instr,
    output logic        legal,
    output red_op_e     op,
    output logic        vm
);
    // Field extraction and legality test.
    always_comb begin
        legal = (instr[6:0] == VEC_MAJOR) && (instr[14:12] == RED_F3) &&
                (instr[31:29] == 3'b000);
        op    = red_op_e'(instr[28:26]);
        vm    = instr[25];
    end
endmodule

// File: rtl/vred_pick.sv
// Module: element picker. Selects element idx of the latched source at
// the latched width and reports whether it takes part (below vl and
// either unmasked or mask bit set). Assumes vl <= VLEN/SEW.
module vred_pick
    import vred_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int NEL  = VLEN / 8,
    parameter int IDXW = $clog2(NEL + 1)
)(
    input  logic [VLEN-1:0] vec,
    input  logic [NEL-1:0]  mask,
    input  logic [IDXW-1:0] idx,
    input  logic [IDXW-1:0] vl,
    input  logic            vm,
    input  ew_e             ew,
    output logic [DW-1:0]   elem,
    output logic            active
);
    logic [NEL:0]   mask_ext;
    logic [VLEN-1:0] shifted;
    int unsigned     shamt;

    // Shift the wanted element down and trim it to SEW.
    always_comb begin
        mask_ext = {1'b0, mask};
        shamt    = 32'(idx) * ew_bits(ew);
        shifted  = vec >> shamt;
        elem     = shifted[DW-1:0] & ew_keep(ew);
        active   = (idx < vl) && (vm || mask_ext[idx]);
    end
endmodule

// File: rtl/vred_alu.sv
// Module: reduction combiner. Merges accumulator and element under the
// selected operation; both inputs are already trimmed to SEW and the
// result is trimmed again so sums wrap modulo 2^SEW.
module vred_alu
    import vred_pkg::*;
(
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] elem,
    input  red_op_e       op,
    input  ew_e           ew,
    output logic [DW-1:0] result
);
    logic signed [DW:0] acc_s, elem_s;
    logic               s_lt, u_lt;
    logic [DW-1:0]      raw;

    // Compare both ways, then select the operation.
    always_comb begin
        acc_s  = ew_sext(acc, ew);
        elem_s = ew_sext(elem, ew);
        s_lt   = elem_s < acc_s;
        u_lt   = elem < acc;
        case (op)
            OP_SUM:  raw = acc + elem;
            OP_AND:  raw = acc & elem;
            OP_OR:   raw = acc | elem;
            OP_XOR:  raw = acc ^ elem;
            OP_MINU: raw = u_lt ? elem : acc;
            OP_MIN:  raw = s_lt ? elem : acc;
            OP_MAXU: raw = (!u_lt && elem != acc) ? elem : acc;
            default: raw = (!s_lt && elem_s != acc_s) ? elem : acc;
        endcase
        result = raw & ew_keep(ew);
    end
endmodule

// File: rtl/vred_unit.sv
// Module: vector integer reduction unit (top).
// Latches operands on an idle start, folds one element per cycle into a
// seeded accumulator, then writes the result into element 0 of a zeroed
// destination image with a one-cycle done pulse. Illegal words pulse
// illegal_o and leave dest_o alone. Starts while busy are dropped.
module vred_unit
    import vred_pkg::*;
#(
    parameter int VLEN = 128,
    localparam int NEL  = VLEN / 8,
    localparam int VLW  = $clog2(NEL + 1)
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [31:0]     instr_i,
    input  logic [1:0]      ew_i,
    input  logic [VLW-1:0]  vl_i,
    input  logic [63:0]     seed_i,
    input  logic [VLEN-1:0] src_i,
    input  logic [NEL-1:0]  mask_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            illegal_o,
    output logic [VLEN-1:0] dest_o
);
    logic            dec_legal, dec_vm;
    red_op_e         dec_op;

    logic            busy_q, done_q, ill_q, vm_q;
    logic [VLW-1:0]  idx_q, vl_q;
    logic [DW-1:0]   acc_q;
    logic [VLEN-1:0] src_q, dest_q;
    logic [NEL-1:0]  mask_q;
    red_op_e         op_q;
    ew_e             ew_q;

    logic [DW-1:0]   elem, alu_out;
    logic            elem_on;

    vred_decode u_dec (
        .instr (instr_i),
        .legal (dec_legal),
        .op    (dec_op),
        .vm    (dec_vm)
    );

    vred_pick #(.VLEN(VLEN), .NEL(NEL), .IDXW(VLW)) u_pick (
        .vec    (src_q),
        .mask   (mask_q),
        .idx    (idx_q),
        .vl     (vl_q),
        .vm     (vm_q),
        .ew     (ew_q),
        .elem   (elem),
        .active (elem_on)
    );

    vred_alu u_alu (
        .acc    (acc_q),
        .elem   (elem),
        .op     (op_q),
        .ew     (ew_q),
        .result (alu_out)
    );

    // Sequencer: accept, step through elements, finish or flag illegal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            ill_q  <= 1'b0;
            vm_q   <= 1'b0;
            idx_q  <= '0;
            vl_q   <= '0;
            acc_q  <= '0;
            src_q  <= '0;
            mask_q <= '0;
            op_q   <= OP_SUM;
            ew_q   <= EW8;
            dest_q <= '0;
        end else begin
            done_q <= 1'b0;
            ill_q  <= 1'b0;
            if (!busy_q) begin
                if (start_i) begin
                    if (dec_legal) begin
                        busy_q <= 1'b1;
                        idx_q  <= '0;
                        vl_q   <= vl_i;
                        vm_q   <= dec_vm;
                        op_q   <= dec_op;
                        ew_q   <= ew_e'(ew_i);
                        acc_q  <= seed_i & ew_keep(ew_e'(ew_i));
                        src_q  <= src_i;
                        mask_q <= mask_i;
                    end else begin
                        ill_q <= 1'b1;
                    end
                end
            end else if (idx_q == vl_q) begin
                dest_q <= VLEN'(acc_q);
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end else begin
                if (elem_on) acc_q <= alu_out;
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign busy_o    = busy_q;
    assign done_o    = done_q;
    assign illegal_o = ill_q;
    assign dest_o    = dest_q;
endmodule

// File: rtl/vred_chk.sv
// Module: protocol checker for vred_unit, attached by bind below.
module vred_chk #(
    parameter int VLEN = 128
)(
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            busy_o,
    input logic            done_o,
    input logic            illegal_o,
    input logic [VLEN-1:0] dest_o
);
    // R9
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o) && !busy_o);
    // R10
    busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i) && !$past(busy_o));
    // R11
    illegal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !done_o && !busy_o && $stable(dest_o));
    // R11
    illegal_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> $past(start_i) && !$past(busy_o));
    // R7
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (dest_o >> 64) == '0);
    // R9
    dest_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(dest_o));
    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

bind vred_unit vred_chk #(.VLEN(VLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .illegal_o (illegal_o),
    .dest_o    (dest_o)
);

// File: tb/vred_unit_test.sv
// Bench: directed corners plus seeded random reductions against a model.
module vred_unit_test;
    localparam int VLEN = 128;
    localparam int NEL  = VLEN / 8;
    localparam int VLW  = $clog2(NEL + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [31:0]     instr_i = '0;
    logic [1:0]      ew_i = '0;
    logic [VLW-1:0]  vl_i = '0;
    logic [63:0]     seed_i = '0;
    logic [VLEN-1:0] src_i = '0;
    logic [NEL-1:0]  mask_i = '0;
    logic            busy_o, done_o, illegal_o;
    logic [VLEN-1:0] dest_o;

    int n_vec = 0;
    int n_bad = 0;
    logic [VLEN-1:0] last_dest = '0;

    always #2 clk = ~clk;

    vred_unit #(.VLEN(VLEN)) uut (.*);

    function automatic logic [31:0] mk_instr(int op, bit vm);
        logic [31:0] w;
        w = 32'($urandom);
        w[31:29] = 3'b000;
        w[28:26] = 3'(op);
        w[25]    = vm;
        w[14:12] = 3'b010;
        w[6:0]   = 7'b1010111;
        return w;
    endfunction

    // Reference reduction from the requirements.
    function automatic logic [VLEN-1:0] ref_red(logic [31:0] ins, logic [1:0] ew,
            int vl, logic [63:0] seed, logic [VLEN-1:0] src, logic [NEL-1:0] msk);
        int w = 8 << ew;
        logic [63:0] keep, sbit, acc, e;
        int op = int'(ins[28:26]);
        keep = (w == 64) ? '1 : ((64'd1 << w) - 1);
        sbit = 64'd1 << (w - 1);
        acc  = seed & keep;
        for (int i = 0; i < vl; i++) begin
            e = 64'(src >> (i * w)) & keep;
            if (ins[25] || msk[i]) begin
                case (op)
                    0: acc = (acc + e) & keep;
                    1: acc = acc & e;
                    2: acc = acc | e;
                    3: acc = acc ^ e;
                    4: if (e < acc) acc = e;
                    5: if ((e ^ sbit) < (acc ^ sbit)) acc = e;
                    6: if (e > acc) acc = e;
                    default: if ((e ^ sbit) > (acc ^ sbit)) acc = e;
                endcase
            end
        end
        return VLEN'(acc);
    endfunction

    task automatic check(bit ok, string req, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Run one legal reduction; check latency and result.
    task automatic run(logic [31:0] ins, logic [1:0] ew, int vl, logic [63:0] seed,
            logic [VLEN-1:0] src, logic [NEL-1:0] msk, string req);
        logic [VLEN-1:0] exp;
        int n;
        exp = ref_red(ins, ew, vl, seed, src, msk);
        @(negedge clk);
        instr_i = ins; ew_i = ew; vl_i = VLW'(vl); seed_i = seed; src_i = src; mask_i = msk;
        start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0;
        n = 0;
        while (n < 100) begin
            @(posedge clk); #1 n++;
            if (done_o) break;
        end
        check(n == vl + 1, {"R9 latency ", req}, VLEN'(n), VLEN'(vl + 1));
        check(dest_o == exp, req, dest_o, exp);
        last_dest = dest_o;
    endtask

    initial begin
        logic [31:0] ins;
        logic [1:0]  ew;
        int vl, n;
        bit saw_ill, saw_done;
        void'($urandom(32'd20240611));

        repeat (3) @(posedge clk);
        #1;
        // R12 reset state
        check(dest_o == '0 && !busy_o && !done_o && !illegal_o, "R12", dest_o, '0);
        @(negedge clk) rst_n = 1'b1;

        // R3 sum wraps at 8 bits
        run(mk_instr(0, 1), 2'b00, 1, 64'hFF, VLEN'(8'h01), '0, "R3 wrap");
        // R2 seed used as start, R8 vl zero
        run(mk_instr(2, 1), 2'b01, 0, 64'hDEAD_BEEF_1234_5678, '1, '1, "R8 R2 vl0");
        // R4 signed vs unsigned min
        run(mk_instr(5, 1), 2'b00, 2, 64'h01, {112'd0, 8'h7F, 8'h80}, '0, "R4 smin");
        run(mk_instr(4, 1), 2'b00, 2, 64'h01, {112'd0, 8'h7F, 8'h80}, '0, "R4 umin");
        run(mk_instr(7, 1), 2'b10, 4, 64'hFFFF_FFFF, {32'h8000_0000, 32'h7FFF_FFFF, 64'd0}, '0, "R4 smax");
        run(mk_instr(6, 1), 2'b10, 4, 64'h1, {32'h8000_0000, 32'h7FFF_FFFF, 64'd0}, '0, "R4 umax");
        // R5 all masked off returns seed
        run(mk_instr(0, 0), 2'b00, 16, 64'h5A, '1, '0, "R5 all off");
        // R5 alternate mask, R6 64-bit width, R7 upper zero
        run(mk_instr(3, 0), 2'b11, 2, 64'h1111, {64'hFFFF, 64'hF0F0}, 16'h0002, "R5 R6 R7 xor64");
        run(mk_instr(1, 1), 2'b01, 8, 64'hFFFF, {8{16'hF00F}}, '0, "R1 and16");

        // R11 illegal word: wrong funct3, wrong funct6, wrong opcode
        for (int k = 0; k < 3; k++) begin
            ins = mk_instr(0, 1);
            if (k == 0) ins[14:12] = 3'b000;
            if (k == 1) ins[31] = 1'b1;
            if (k == 2) ins[6:0] = 7'b0110011;
            @(negedge clk);
            instr_i = ins; vl_i = 4; start_i = 1'b1;
            @(posedge clk); #1 start_i = 1'b0;
            check(illegal_o && !busy_o && dest_o == last_dest, "R11 R1 flag", dest_o, last_dest);
            @(posedge clk); #1;
            check(!illegal_o && !done_o && dest_o == last_dest, "R11 quiet", dest_o, last_dest);
        end

        // R10 start held through a busy run, including the finishing edge
        for (int k = 0; k < 2; k++) begin
            logic [VLEN-1:0] exp, src;
            src = {$urandom, $urandom, $urandom, $urandom};
            ins = mk_instr(0, 1);
            exp = ref_red(ins, 2'b00, 8, 64'h3, src, '0);
            @(negedge clk);
            instr_i = ins; ew_i = 0; vl_i = 8; seed_i = 64'h3; src_i = src; mask_i = '0;
            start_i = 1'b1;
            @(posedge clk); #1;
            instr_i = (k == 0) ? mk_instr(6, 1) : 32'h0; seed_i = 64'hFF;
            n = 0; saw_ill = 0;
            while (n < 100) begin
                @(posedge clk); #1 n++;
                if (illegal_o) saw_ill = 1;
                if (done_o) break;
            end
            start_i = 1'b0;
            check(n == 9 && dest_o == exp, "R10 result", dest_o, exp);
            last_dest = dest_o;
            saw_done = 0;
            repeat (4) begin
                @(posedge clk); #1;
                if (done_o) saw_done = 1;
                if (illegal_o) saw_ill = 1;
            end
            check(!saw_done && !saw_ill && !busy_o, "R10 no extra pulse", VLEN'(saw_done), '0);
        end

        // Random mix (R1 to R9)
        for (int k = 0; k < 300; k++) begin
            ew = 2'($urandom_range(3));
            vl = $urandom_range(VLEN / (8 << ew));
            run(mk_instr($urandom_range(7), 1'($urandom)), ew, vl,
                {$urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
                NEL'($urandom), "R3 R5 R6 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_vec++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule